// File: doc/BRIEF.md
# Watch Timer with Buzzer Output

A free-running binary divider chain advanced by a watch clock enable. The watch clock enable comes either from an internal prescaler that divides the system clock by a power of two, or from a single-cycle tick pulse supplied by a slow clock source outside the block. One chain serves two purposes. It raises a periodic watch request at a long real-time interval or at a short interval meant for fast testing. It also provides four buzzer frequencies, taken directly from its low bits.

Software sets the block up through one 8-bit mode register. The register enables the block, selects the clock source, selects the interval and selects the buzzer tap. The request is a sticky flag. Software polls it, or a power-down controller outside the block uses it as a wake-up source, and software clears it with a one-cycle pulse. With the defaults and a 4.194304 MHz system clock, the watch clock is 32.768 kHz, the intervals are 0.5 s and 3.91 ms, and the buzzer runs at 2, 4, 8 or 16 kHz.

Top module: `watch_timer`

## Requirements
- R1: After reset, irq_flag_o and buzz_o are low and the mode register is all zero, so the block is disabled.
- R2: Mode register layout, loaded from mode_wdata_i on a cycle with mode_we_i high and effective from the next cycle. Bit 0 enables the block. Bit 1 selects the clock source: 0 is the internal prescaler, 1 is sub_tick_i. Bit 2 selects the interval: 0 is long, 1 is short. Bits 4:3 select the buzzer divisor of the watch clock: 0 gives /16, 1 gives /8, 2 gives /4 and 3 gives /2. Bits 7:5 have no effect.
- R3: With the internal source selected, the chain advances once every 2^PRE_W system clocks, counted from the write that enables the block, and sub_tick_i has no effect.
- R4: With the external source selected, the chain advances once for each cycle in which sub_tick_i is high while the block is enabled.
- R5: In short mode, irq_flag_o rises after every 2^SHORT_W watch ticks. Counted from enable, the first rise comes exactly 2^SHORT_W watch ticks after enable.
- R6: In long mode, irq_flag_o rises once every 2^CHAIN_W watch ticks. It does not rise at the short interval.
- R7: buzz_o is a 50% duty square wave whose period is 2^(4-sel) watch ticks, where sel is mode bits 4:3. It starts low at enable.
- R8: While the block is disabled, buzz_o is low, the prescaler and chain are held at zero, and no new request is raised. On re-enable, counting starts from zero.
- R9: irq_flag_o stays high until a cycle with flag_clr_i high. If a clear and a new interval tick fall in the same cycle, the flag stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_we_i | input | 1 | Mode register write strobe |
| mode_wdata_i | input | 8 | Mode register write data |
| sub_tick_i | input | 1 | Watch clock enable pulse from the slow source |
| flag_clr_i | input | 1 | Clears the watch request flag |
| irq_flag_o | output | 1 | Sticky watch request flag |
| buzz_o | output | 1 | Buzzer square wave |

## Verification
The assertions assume that sub_tick_i is a synchronous enable pulse, with no more than one pulse in each cycle. They also assume that flag_clr_i and mode_we_i are plain synchronous strobes. Given those inputs, the assertions check the chain, the flag and the buzzer gating for every mode sequence. The bench drives every input on the falling clock edge and produces slow ticks only as one-cycle pulses. It clears the flag only while the block is disabled, or in cycles it has chosen on purpose, such as the cycle that coincides with a tick. To keep the long interval within reach, the bench shrinks the prescaler and chain widths through parameters.

// File: rtl/wt_pkg.sv
package wt_pkg;
  typedef struct packed {
    logic [1:0] buz_sel;
    logic       intv_short;
    logic       clk_ext;
    logic       en;
  } wt_mode_t;

  localparam int unsigned BUZ_TOP_TAP = 3;
endpackage

// File: rtl/wt_prescale.sv
module wt_prescale #(
  parameter int unsigned PRE_W = 7
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  logic [PRE_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (!en_i) cnt_q <= '0;
    else            cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = en_i && (&cnt_q);
endmodule

// File: rtl/wt_chain.sv
module wt_chain #(
  parameter int unsigned CHAIN_W = 14
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic               step_i,
  output logic [CHAIN_W-1:0] chain_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      chain_o <= '0;
    else if (!en_i)   chain_o <= '0;
    else if (step_i)  chain_o <= chain_o + 1'b1;
  end
endmodule

// File: rtl/wt_flag.sv
module wt_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  // set wins over a coincident clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_o <= 1'b0;
    else if (set_i)  flag_o <= 1'b1;
    else if (clr_i)  flag_o <= 1'b0;
  end
endmodule

// File: rtl/watch_timer.sv
module watch_timer #(
  parameter int unsigned PRE_W   = 7,
  parameter int unsigned CHAIN_W = 14,
  parameter int unsigned SHORT_W = 7
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       mode_we_i,
  input  logic [7:0] mode_wdata_i,
  input  logic       sub_tick_i,
  input  logic       flag_clr_i,
  output logic       irq_flag_o,
  output logic       buzz_o
);
  import wt_pkg::*;

  localparam int unsigned MODE_W = $bits(wt_mode_t);

  wt_mode_t           mode_q;
  logic               en;
  logic               pre_tick;
  logic               watch_tick;
  logic [CHAIN_W-1:0] chain;
  logic               short_hit;
  logic               long_hit;
  logic               irq_set;
  logic [1:0]         tap_idx;
  logic               unused_rsvd;

  assign unused_rsvd = ^mode_wdata_i[7:MODE_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        mode_q <= '0;
    else if (mode_we_i) mode_q <= wt_mode_t'(mode_wdata_i[MODE_W-1:0]);
  end

  assign en = mode_q.en;

  wt_prescale #(.PRE_W(PRE_W)) u_pre (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (en),
    .tick_o(pre_tick)
  );

  assign watch_tick = mode_q.clk_ext ? (en && sub_tick_i) : pre_tick;

  wt_chain #(.CHAIN_W(CHAIN_W)) u_chain (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en),
    .step_i (watch_tick),
    .chain_o(chain)
  );

  assign short_hit = watch_tick && (&chain[SHORT_W-1:0]);
  assign long_hit  = watch_tick && (&chain);
  assign irq_set   = mode_q.intv_short ? short_hit : long_hit;

  wt_flag u_flag (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (irq_set),
    .clr_i (flag_clr_i),
    .flag_o(irq_flag_o)
  );

  // sel 0 -> bit 3 (/16) ... sel 3 -> bit 0 (/2)
  assign tap_idx = 2'(BUZ_TOP_TAP) - mode_q.buz_sel;
  assign buzz_o  = en && chain[tap_idx];
endmodule

// File: rtl/watch_timer_chk.sv
module watch_timer_chk #(
  parameter int unsigned CHAIN_W = 14
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               en_i,
  input logic               watch_tick_i,
  input logic [CHAIN_W-1:0] chain_i,
  input logic               irq_set_i,
  input logic               flag_clr_i,
  input logic               irq_flag_i,
  input logic               buzz_i
);
  AST_BUZ_LOW_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> !buzz_i); // R8
  AST_CHAIN_CLEAR_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> chain_i == '0); // R8
  AST_CHAIN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !watch_tick_i) |=> $stable(chain_i)); // R3
  AST_CHAIN_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && watch_tick_i) |=> chain_i == $past(chain_i) + 1'b1); // R4
  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_flag_i && !flag_clr_i) |=> irq_flag_i); // R9
  AST_FLAG_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_set_i |=> irq_flag_i); // R9
  AST_FLAG_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_clr_i && !irq_set_i) |=> !irq_flag_i); // R9
  AST_NO_SET_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> !irq_set_i); // R8
endmodule

bind watch_timer watch_timer_chk #(.CHAIN_W(CHAIN_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .en_i        (en),
  .watch_tick_i(watch_tick),
  .chain_i     (chain),
  .irq_set_i   (irq_set),
  .flag_clr_i  (flag_clr_i),
  .irq_flag_i  (irq_flag_o),
  .buzz_i      (buzz_o)
);

// File: tb/watch_timer_test.sv
module watch_timer_test;
  localparam int CLK_PERIOD = 10;
  localparam int PRE_W   = 2;
  localparam int CHAIN_W = 8;
  localparam int SHORT_W = 3;
  localparam int P       = 1 << PRE_W;
  localparam int SHORT_N = (1 << SHORT_W) * P;
  localparam int LONG_N  = (1 << CHAIN_W) * P;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_we = 1'b0;
  logic [7:0] mode_wdata = '0;
  logic       sub_tick = 1'b0;
  logic       flag_clr = 1'b0;
  logic       irq_flag;
  logic       buzz;

  int errs = 0;
  int checks = 0;
  int ncur = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  watch_timer #(.PRE_W(PRE_W), .CHAIN_W(CHAIN_W), .SHORT_W(SHORT_W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .mode_we_i(mode_we), .mode_wdata_i(mode_wdata),
    .sub_tick_i(sub_tick), .flag_clr_i(flag_clr), .irq_flag_o(irq_flag), .buzz_o(buzz)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    ncur++;
  endtask

  task automatic wait_to(input int n);
    while (ncur < n) step();
  endtask

  task automatic write_mode(input logic [7:0] d);
    @(negedge clk);
    mode_we = 1'b1; mode_wdata = d;
    @(negedge clk);
    mode_we = 1'b0;
    ncur = 0;
  endtask

  task automatic clear_flag();
    @(negedge clk); flag_clr = 1'b1;
    @(negedge clk); flag_clr = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 flag after reset", irq_flag, 0);
    chk("R1 buzz after reset", buzz, 0);
    repeat (SHORT_N + 4) @(negedge clk);
    chk("R1 disabled, no request", irq_flag, 0);
  endtask

  task automatic t_short_internal();
    write_mode(8'h05);
    sub_tick = 1'b1; // R3: ignored on internal source
    wait_to(SHORT_N - 1);
    chk("R5 flag before short interval", irq_flag, 0);
    step();
    chk("R5 flag at short interval", irq_flag, 1);
    chk("R3 sub_tick ignored", ncur, SHORT_N);
    sub_tick = 1'b0;
    wait_to(SHORT_N + 20);
    chk("R9 flag held", irq_flag, 1);
    wait_to(2 * SHORT_N - 1);
    flag_clr = 1'b1;
    step();
    flag_clr = 1'b0;
    chk("R9 set beats clear", irq_flag, 1);
    flag_clr = 1'b1;
    step();
    flag_clr = 1'b0;
    chk("R9 clear takes effect", irq_flag, 0);
    write_mode(8'h00);
    clear_flag();
  endtask

  task automatic t_long();
    write_mode(8'h01);
    wait_to(SHORT_N);
    chk("R6 no request at short interval", irq_flag, 0);
    wait_to(LONG_N - 1);
    chk("R6 flag before long interval", irq_flag, 0);
    step();
    chk("R6 flag at long interval", irq_flag, 1);
    write_mode(8'h00);
    clear_flag();
  endtask

  task automatic t_external();
    write_mode(8'h07);
    for (int k = 1; k <= (1 << SHORT_W); k++) begin
      repeat (3) @(negedge clk);
      sub_tick = 1'b1;
      @(negedge clk);
      sub_tick = 1'b0;
      if (k == (1 << SHORT_W) - 1) chk("R4 flag before last slow tick", irq_flag, 0);
    end
    chk("R4 flag after 2^SHORT_W slow ticks", irq_flag, 1);
    write_mode(8'h00);
    clear_flag();
  endtask

  task automatic t_buzz(input int sel);
    int bad = 0;
    int first_act = 0;
    int first_exp = 0;
    write_mode(8'h01 | 8'(sel << 3));
    for (int n = 0; n < 40 * P; n++) begin
      int e;
      e = ((n / P) >> (3 - sel)) & 1;
      if (buzz !== e[0] && bad == 0) begin
        bad = 1; first_act = buzz; first_exp = e;
      end
      step();
    end
    chk($sformatf("R7 buzzer waveform sel=%0d", sel), first_act + bad * 2, first_exp);
    write_mode(8'h00);
    chk("R8 buzz low after disable", buzz, 0);
  endtask

  task automatic t_disable();
    write_mode(8'h1D); // short, sel 3, enabled
    wait_to(5 * P);
    chk("R7 buzz high mid-run", buzz, 1);
    write_mode(8'hE0); // R2: high bits only, block disabled
    chk("R8 buzz low when disabled", buzz, 0);
    repeat (3 * SHORT_N) @(negedge clk);
    chk("R8 no request while disabled", irq_flag, 0);
    write_mode(8'hE5); // R2: reserved bits have no effect
    wait_to(SHORT_N - 1);
    chk("R8 restart from zero, before", irq_flag, 0);
    step();
    chk("R8 restart from zero, at interval", irq_flag, 1);
    write_mode(8'h00);
    clear_flag();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_short_internal();
    t_long();
    t_external();
    for (int s = 0; s < 4; s++) t_buzz(s);
    t_disable();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule